// File: doc/BRIEF.md
# Multi-Channel Phase-Offset PWM Generator

This block drives a set of independent pulse-width-modulated outputs from a single clock. Each output channel is described by three cycle counts: the length of its period, how many cycles after the start of the period the pulse begins (the offset), and how many cycles the pulse lasts (the duty length). Shifting the pulse inside the period lets several channels run at the same frequency with staggered edges. Examples are interleaved converter phases and time-sliced sampling strobes.

Software programs the channels through a simple synchronous register port. Period, duty and offset writes land in pending storage and do not disturb the running waveform. A write to the load register copies every pending value into the working set in one clock edge. The same edge restarts every channel's period counter, so all outputs begin a fresh period together and stay phase-aligned. A per-channel enable mask acts immediately. A disabled channel's output is held low, but its counter keeps running. Outputs are active high only.

Top module: `pwm_phase_gen`

## Requirements
- R1: After reset every PWM output is low, the enable mask reads 0 and every channel register reads 0.
- R2: Address 0x00 is read-only and returns 0x0002_0000 (major version 2 in bits 31:16, all other bits 0). A write to it changes nothing.
- R3: Writes to a channel's period (0x40+12k), duty (0x44+12k) or offset (0x48+12k) do not change any output until the load register is written. Reading these addresses returns the pending value just written.
- R4: A write of any value to address 0x04 copies all pending values into the working set. At the same clock edge it restarts every channel's cycle counter. In the first cycle after that edge every counter is at position 0, regardless of where it was before.
- R5: With period P>0, duty D and offset O<P, the counter steps 0,1,..,P-1 and wraps. The output is high exactly when O <= position < O+D.
- R6: A duty value larger than the period is treated as equal to the period. The pulse never wraps past the end of the period: with D=P and O=0 the output is high in every cycle.
- R7: An offset greater than or equal to the period keeps the output low for the whole period.
- R8: A period of 0 keeps the output permanently low.
- R9: Bit k of the enable mask at 0x08 gates channel k. It takes effect at the clock edge of the write, with no load needed. A disabled channel's output is low, and its counter keeps its phase, so re-enabling resumes the waveform in step.
- R10: Addresses outside the map read 0, and writes to them have no effect on any register or output.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, all state updates on its rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| reg_addr | input | 8 | Byte address of the register being accessed |
| reg_wdata | input | 32 | Write data |
| reg_we | input | 1 | Write enable, one write per cycle with it high |
| reg_rdata | output | 32 | Read data for reg_addr, combinational from register state |
| pwm_o | output | 4 | One PWM output per channel, active high |

## Verification
A counter that drifts, fails to restart, or holds a stale working value shows up within one period. The output rises or falls a cycle or more away from where the reference model places it. The bench compares every channel in every cycle of several whole periods after each load, so any such fault is caught within a single period. A pending value leaking into the working set early shows at the first cycle of the next high window. An enable mask that resets the counter shows as a shifted pulse right after re-enable.

// File: rtl/pwmg_pkg.sv
package pwmg_pkg;
   localparam int unsigned VER_MAJOR = 2;
   localparam int unsigned CH_STRIDE = 12;

   typedef enum logic [1:0] {
      FLD_PERIOD = 2'd0,
      FLD_DUTY   = 2'd1,
      FLD_OFFSET = 2'd2,
      FLD_NONE   = 2'd3
   } field_e;
endpackage

// File: rtl/pwmg_regs.sv
module pwmg_regs
   import pwmg_pkg::*;
#(
   parameter int unsigned NCH     = 4,
   parameter int unsigned CW      = 16,
   parameter int unsigned AW      = 8,
   parameter int unsigned DW      = 32,
   parameter int unsigned CH_BASE = 64
) (
   input  logic                    clk,
   input  logic                    rst_n,
   input  logic [AW-1:0]           addr,
   input  logic [DW-1:0]           wdata,
   input  logic                    we,
   output logic [DW-1:0]           rdata,
   output logic                    load,
   output logic [NCH-1:0]          chan_en,
   output logic [NCH-1:0][CW-1:0]  act_per,
   output logic [NCH-1:0][CW-1:0]  act_duty,
   output logic [NCH-1:0][CW-1:0]  act_off
);
   localparam logic [AW-1:0] A_VER  = AW'(0);
   localparam logic [AW-1:0] A_LOAD = AW'(4);
   localparam logic [AW-1:0] A_EN   = AW'(8);
   localparam logic [DW-1:0] VER_WORD = DW'(VER_MAJOR) << 16;
   localparam int unsigned   CIW = (NCH > 1) ? $clog2(NCH) : 1;

   generate
      if (NCH < 1 || NCH > DW) begin : g_bad_nch
         $error("pwmg_regs: NCH must be 1..DW");
      end
      if (CW < 2 || CW > DW) begin : g_bad_cw
         $error("pwmg_regs: CW must be 2..DW");
      end
      if (DW < 24) begin : g_bad_dw
         $error("pwmg_regs: DW must hold the version field");
      end
      if (CH_BASE + CH_STRIDE * NCH > (1 << AW) || CH_BASE < 12) begin : g_bad_map
         $error("pwmg_regs: channel window does not fit the address space");
      end
   endgenerate

   logic [NCH-1:0][CW-1:0] sh_per, sh_duty, sh_off;
   field_e                 fld;
   logic [CIW-1:0]         sel;

   always_comb begin
      fld = FLD_NONE;
      sel = '0;
      for (int k = 0; k < NCH; k++) begin
         if (addr == AW'(CH_BASE + CH_STRIDE * k)) begin
            fld = FLD_PERIOD; sel = CIW'(k);
         end else if (addr == AW'(CH_BASE + CH_STRIDE * k + 4)) begin
            fld = FLD_DUTY;   sel = CIW'(k);
         end else if (addr == AW'(CH_BASE + CH_STRIDE * k + 8)) begin
            fld = FLD_OFFSET; sel = CIW'(k);
         end
      end
   end

   assign load = we && (addr == A_LOAD);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         sh_per  <= '0;
         sh_duty <= '0;
         sh_off  <= '0;
         chan_en <= '0;
      end else if (we) begin
         case (fld)
            FLD_PERIOD: sh_per[sel]  <= wdata[CW-1:0];
            FLD_DUTY:   sh_duty[sel] <= wdata[CW-1:0];
            FLD_OFFSET: sh_off[sel]  <= wdata[CW-1:0];
            default: begin
               if (addr == A_EN) chan_en <= wdata[NCH-1:0];
            end
         endcase
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         act_per  <= '0;
         act_duty <= '0;
         act_off  <= '0;
      end else if (load) begin
         act_per  <= sh_per;
         act_duty <= sh_duty;
         act_off  <= sh_off;
      end
   end

   always_comb begin
      rdata = '0;
      case (fld)
         FLD_PERIOD: rdata = DW'(sh_per[sel]);
         FLD_DUTY:   rdata = DW'(sh_duty[sel]);
         FLD_OFFSET: rdata = DW'(sh_off[sel]);
         default: begin
            if (addr == A_VER)     rdata = VER_WORD;
            else if (addr == A_EN) rdata = DW'(chan_en);
         end
      endcase
   end

   AST_ACTIVE_HELD: assert property (@(posedge clk) disable iff (!rst_n)
      !load |=> ($stable(act_per) && $stable(act_duty) && $stable(act_off))); // R3
   AST_ACTIVE_TAKES_PENDING: assert property (@(posedge clk) disable iff (!rst_n)
      load |=> (act_per == $past(sh_per) && act_off == $past(sh_off))); // R4
   AST_VERSION_READ: assert property (@(posedge clk) disable iff (!rst_n)
      (addr == A_VER) |-> (rdata == VER_WORD)); // R2
endmodule

// File: rtl/pwmg_chan.sv
module pwmg_chan #(
   parameter int unsigned CW = 16
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          restart,
   input  logic          en,
   input  logic [CW-1:0] per,
   input  logic [CW-1:0] duty,
   input  logic [CW-1:0] off,
   output logic          pwm
);
   logic [CW-1:0] cnt;
   logic [CW-1:0] duty_eff;
   logic [CW:0]   win_end;
   logic          in_win;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                   cnt <= '0;
      else if (restart)             cnt <= '0;
      else if (per == '0)           cnt <= '0;
      else if (cnt >= per - 1'b1)   cnt <= '0;
      else                          cnt <= cnt + 1'b1;
   end

   assign duty_eff = (duty > per) ? per : duty;
   assign win_end  = {1'b0, off} + {1'b0, duty_eff};
   assign in_win   = (per != '0) && (off < per) && (cnt >= off) && ({1'b0, cnt} < win_end);
   assign pwm      = en && in_win;

   AST_CNT_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
      (per == '0) ? (cnt == '0) : (cnt < per)); // R5
   AST_RESTART_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
      restart |=> (cnt == '0)); // R4
   AST_OFFSET_SILENT: assert property (@(posedge clk) disable iff (!rst_n)
      (off >= per) |-> !pwm); // R7
   AST_DISABLED_LOW: assert property (@(posedge clk) disable iff (!rst_n)
      !en |-> !pwm); // R9
   AST_ZERO_PERIOD_LOW: assert property (@(posedge clk) disable iff (!rst_n)
      (per == '0) |-> !pwm); // R8
endmodule

// File: rtl/pwm_phase_gen.sv
module pwm_phase_gen #(
   parameter int unsigned NCH     = 4,
   parameter int unsigned CW      = 16,
   parameter int unsigned AW      = 8,
   parameter int unsigned DW      = 32,
   parameter int unsigned CH_BASE = 64
) (
   input  logic           clk,
   input  logic           rst_n,
   input  logic [AW-1:0]  reg_addr,
   input  logic [DW-1:0]  reg_wdata,
   input  logic           reg_we,
   output logic [DW-1:0]  reg_rdata,
   output logic [NCH-1:0] pwm_o
);
   logic                   load;
   logic [NCH-1:0]         chan_en;
   logic [NCH-1:0][CW-1:0] act_per, act_duty, act_off;

   pwmg_regs #(
      .NCH(NCH), .CW(CW), .AW(AW), .DW(DW), .CH_BASE(CH_BASE)
   ) u_regs (
      .clk      (clk),
      .rst_n    (rst_n),
      .addr     (reg_addr),
      .wdata    (reg_wdata),
      .we       (reg_we),
      .rdata    (reg_rdata),
      .load     (load),
      .chan_en  (chan_en),
      .act_per  (act_per),
      .act_duty (act_duty),
      .act_off  (act_off)
   );

   generate
      for (genvar k = 0; k < NCH; k++) begin : g_ch
         pwmg_chan #(.CW(CW)) u_chan (
            .clk     (clk),
            .rst_n   (rst_n),
            .restart (load),
            .en      (chan_en[k]),
            .per     (act_per[k]),
            .duty    (act_duty[k]),
            .off     (act_off[k]),
            .pwm     (pwm_o[k])
         );
      end
   endgenerate

   AST_OUT_NEEDS_ENABLE: assert property (@(posedge clk) disable iff (!rst_n)
      (pwm_o & ~chan_en) == '0); // R9
   AST_RESET_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(rst_n) |-> (pwm_o == '0)); // R1
endmodule

// File: tb/tb_pwm_phase_gen.sv
module tb_pwm_phase_gen;
   localparam int NCH = 4;
   localparam int CW  = 16;

   logic           clk = 0;
   logic           rst_n = 0;
   logic [7:0]     reg_addr = '0;
   logic [31:0]    reg_wdata = '0;
   logic           reg_we = 0;
   logic [31:0]    reg_rdata;
   logic [NCH-1:0] pwm_o;

   pwm_phase_gen #(.NCH(NCH), .CW(CW)) dut (
      .clk(clk), .rst_n(rst_n), .reg_addr(reg_addr), .reg_wdata(reg_wdata),
      .reg_we(reg_we), .reg_rdata(reg_rdata), .pwm_o(pwm_o)
   );

   always #2.5 clk = ~clk;

   int tests = 0;
   int fails = 0;
   int cyc = 0;
   int load_cyc = 0;
   int sp[NCH], sd[NCH], so[NCH];
   int ap[NCH], ad[NCH], ao[NCH];
   bit en_m[NCH];

   always @(posedge clk) cyc <= cyc + 1;

   task automatic chk(string req, int act, int exp);
      tests++;
      if (act != exp) begin
         fails++;
         $display("FAIL %s: actual %0h expected %0h", req, act, exp);
      end
   endtask

   task automatic wr(int a, int d);
      @(negedge clk);
      reg_addr = 8'(a); reg_wdata = 32'(d); reg_we = 1;
      @(negedge clk);
      reg_we = 0;
      if (a == 4) begin
         load_cyc = cyc;
         for (int k = 0; k < NCH; k++) begin ap[k] = sp[k]; ad[k] = sd[k]; ao[k] = so[k]; end
      end else if (a == 8) begin
         for (int k = 0; k < NCH; k++) en_m[k] = d[k];
      end else if (a >= 64 && a < 64 + 12 * NCH) begin
         case ((a - 64) % 12)
            0: sp[(a - 64) / 12] = d & 16'hffff;
            4: sd[(a - 64) / 12] = d & 16'hffff;
            8: so[(a - 64) / 12] = d & 16'hffff;
            default: ;
         endcase
      end
   endtask

   task automatic rd(int a, output int d);
      @(negedge clk);
      reg_addr = 8'(a);
      #1 d = int'(reg_rdata);
   endtask

   task automatic set_ch(int k, int p, int d, int o);
      wr(64 + 12 * k, p); wr(68 + 12 * k, d); wr(72 + 12 * k, o);
   endtask

   function automatic bit exp_hi(int k, int i);
      int c, dd;
      if (!en_m[k] || ap[k] == 0 || ao[k] >= ap[k]) return 0;
      c  = i % ap[k];
      dd = (ad[k] > ap[k]) ? ap[k] : ad[k];
      return (c >= ao[k]) && (c < ao[k] + dd);
   endfunction

   // compares every channel in every cycle; one tally per channel
   task automatic check_window(string req, int ncyc);
      int bad[NCH], fa[NCH], fe[NCH];
      for (int k = 0; k < NCH; k++) begin bad[k] = 0; fa[k] = 0; fe[k] = 0; end
      for (int n = 0; n < ncyc; n++) begin
         #1;
         for (int k = 0; k < NCH; k++) begin
            if (pwm_o[k] != exp_hi(k, cyc - load_cyc) && bad[k] == 0) begin
               bad[k] = 1; fa[k] = pwm_o[k]; fe[k] = exp_hi(k, cyc - load_cyc);
            end
         end
         @(negedge clk);
      end
      for (int k = 0; k < NCH; k++) chk(req, fa[k], fe[k]);
   endtask

   task automatic t_reset();
      int d;
      chk("R1 outputs", int'(pwm_o), 0);
      rd(8, d);  chk("R1 enable", d, 0);
      rd(64, d); chk("R1 period0", d, 0);
      rd(76 + 8, d); chk("R1 offset1", d, 0);
   endtask

   task automatic t_version();
      int d;
      rd(0, d); chk("R2 version", d, 32'h0002_0000);
      wr(0, 32'h1234_5678);
      rd(0, d); chk("R2 version after write", d, 32'h0002_0000);
   endtask

   task automatic t_basic();
      set_ch(0, 10, 3, 0);
      set_ch(1, 10, 3, 4);
      set_ch(2, 7, 2, 5);
      set_ch(3, 5, 1, 4);
      wr(8, 4'hf);
      wr(4, 0);
      check_window("R5 waveform", 30);
      check_window("R4 alignment", 1);
   endtask

   task automatic t_shadow();
      int d;
      set_ch(0, 6, 5, 1);
      set_ch(1, 4, 1, 0);
      check_window("R3 pending not applied", 25);
      rd(64, d); chk("R3 read pending period", d, 6);
      rd(68, d); chk("R3 read pending duty", d, 5);
      rd(84, d); chk("R3 read pending offset", d, 0);
      wr(4, 1);
      check_window("R3 after load", 24);
   endtask

   task automatic t_restart();
      repeat (3) @(negedge clk);
      wr(4, 32'hffff_ffff);
      check_window("R4 restart mid-period", 20);
   endtask

   task automatic t_clamp();
      set_ch(0, 6, 50, 0);
      set_ch(1, 8, 8, 0);
      set_ch(2, 8, 100, 5);
      wr(4, 0);
      check_window("R6 duty clamp", 24);
   endtask

   task automatic t_offset_zero();
      set_ch(0, 6, 3, 6);
      set_ch(1, 6, 3, 9);
      set_ch(2, 0, 3, 0);
      set_ch(3, 0, 0, 0);
      wr(4, 0);
      check_window("R7 offset >= period", 20);
      chk("R8 zero period low", int'(pwm_o[3:2]), 0);
      check_window("R8 zero period", 10);
   endtask

   task automatic t_enable();
      set_ch(0, 9, 4, 2);
      set_ch(1, 9, 4, 2);
      set_ch(2, 9, 4, 2);
      set_ch(3, 9, 4, 2);
      wr(4, 0);
      check_window("R9 all enabled", 9);
      wr(8, 4'b0101);
      check_window("R9 partial disable", 13);
      wr(8, 4'b1111);
      check_window("R9 re-enable keeps phase", 18);
   endtask

   task automatic t_unmapped();
      int d;
      wr(60, 32'hffff);
      wr(64 + 12 * NCH, 32'h55);
      wr(12, 32'h77);
      rd(60, d); chk("R10 read unmapped 0x3c", d, 0);
      rd(64 + 12 * NCH, d); chk("R10 read past channels", d, 0);
      rd(64, d); chk("R10 ch0 period intact", d, 9);
      rd(8, d);  chk("R10 enable intact", d, 4'hf);
      check_window("R10 outputs undisturbed", 18);
   endtask

   initial begin : watchdog
      repeat (100000) @(posedge clk);
      fails++; tests++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("[TB] %0d tests run, %0d failed", tests, fails);
      $finish;
   end

   initial begin
      for (int k = 0; k < NCH; k++) begin
         sp[k] = 0; sd[k] = 0; so[k] = 0; ap[k] = 0; ad[k] = 0; ao[k] = 0; en_m[k] = 0;
      end
      repeat (3) @(negedge clk);
      rst_n = 1;
      @(negedge clk);
      t_reset();
      t_version();
      t_basic();
      t_shadow();
      t_restart();
      t_clamp();
      t_offset_zero();
      t_enable();
      t_unmapped();
      $display("[TB] %0d tests run, %0d failed", tests, fails);
      $finish;
   end
endmodule